// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter with Prescaler

This block is a 16-bit up-counter that software reaches through a byte-wide register bus. It counts one of two sources. The first is an internal instruction-cycle tick strobe. The second is the rising edges of an external clock input. Before it reaches the counter, the selected source passes through a prescaler that divides it by 1, 2, 4 or 8. The external input normally goes through a two-flop synchronizer. A control bit can bypass that synchronizer, which models a counter that runs without synchronization.

Counting can be qualified by a gate. The gate level comes from an external gate pin or from a comparator output, and it can be inverted. Software can therefore measure how long a signal spends high or how long it spends low. When the count wraps from all ones to zero, a sticky overflow flag is set.

In external mode the counter must see a falling edge before it counts the first rising edge after any of these events: reset, a write to the count, or a re-enable where the input was high when the timer stopped and is low when it restarts. This prevents a spurious first count.

Top module: `gated_tick_timer`

## Requirements
- R1: Register map. Address 0 is the count low byte, address 1 is the count high byte, address 2 is the control byte, and address 3 is status, with the overflow flag in bit 0 and zeros in the other bits. Reads are combinational. After reset the count, control and flag all read 0.
- R2: Control bit 0 (run) enables counting. With the internal source (control bit 1 = 0), the count advances once per prescaled `instrTick` strobe while run is 1. While run is 0 the count holds.
- R3: Control bits 7:6 select the prescale ratio: code 0 divides by 1, code 1 by 2, code 2 by 4 and code 3 by 8. The prescaler only advances on ticks that pass the gate.
- R4: A write to either count byte clears the hidden prescale counter. If a count write and an increment fall in the same cycle, the write wins and no increment happens.
- R5: With control bit 1 = 1 (external source), rising edges of `extClkIn` are counted. With control bit 2 = 0, the input passes two synchronizer flops, and an edge changes the count on the third clock edge. With control bit 2 = 1, an edge changes the count on the next clock edge.
- R6: In external mode a rising edge is counted only after a falling edge has been detected. That arming is cleared by reset, by any count write, and by a re-enable (run going 0 to 1) when the input was high at the stop and is low at the restart.
- R7: Control bit 3 enables the gate. Control bit 5 selects the gate source: 0 selects `gatePin` and 1 selects `cmpOut`. With the gate enabled, counting is allowed only while the effective gate level is 1. With the gate disabled, the gate has no effect.
- R8: Control bit 4 inverts the selected gate level, for either source.
- R9: The count wraps from 0xFFFF to 0x0000 and sets the overflow flag. The flag stays set until software writes 0 to bit 0 of address 3. If an overflow and a flag write fall in the same cycle, the overflow wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrTick | input | 1 | Internal instruction-cycle tick strobe |
| extClkIn | input | 1 | External count input |
| gatePin | input | 1 | External gate pin |
| cmpOut | input | 1 | Comparator output usable as gate |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
Most wrong internal state in this block shows up one or more ticks later as a count that is off by one or more.

- A prescale counter left uncleared by a count write gives an early increment within the following prescale period.
- A stale arming flag gives one extra count on the first rising edge after a write or a re-enable.
- A wrong synchronizer depth moves the count change by a clock edge, so the latency checks sample exactly on the edge where the change is due.
- Gate faults show up over a whole run of ticks, as a count that moves when it should hold or holds when it should move.

// File: rtl/gtt_pkg.sv
package gtt_pkg;
  localparam int BYTE_W  = 8;
  localparam int COUNT_W = 2 * BYTE_W;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 2'd3;

  // Control byte, MSB first: prescale[7:6], gateSel, gateInv, gateEn, bypassSync, srcExt, run
  typedef struct packed {
    logic [1:0] prescale;
    logic       gateSel;
    logic       gateInv;
    logic       gateEn;
    logic       bypassSync;
    logic       srcExt;
    logic       run;
  } tmrCtrl_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic incr;
    logic loadLo;
    logic loadHi;
    logic loadFlag;
  } tmrStrobe_t;
endpackage

// File: rtl/gtt_control.sv
module gtt_control
  import gtt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PS_FIELD_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrTick,
  input  logic              extClkIn,
  input  logic              gatePin,
  input  logic              cmpOut,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output tmrCtrl_t          ctrlReg,
  output tmrStrobe_t        strobe
);
  localparam int PS_CNT_W = (1 << PS_FIELD_W) - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   extLevel, prevLevel, lvlAtStop, runD, armed;
  logic                   riseDet, fallDet, countWrite, reEnableDisarm;
  logic                   srcTick, gateLevel, allowCount, gatedTick;
  logic [PS_CNT_W-1:0]    psCnt, divLimit;

  // Control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (regWrEn && regAddr == ADDR_CTRL) ctrlReg <= tmrCtrl_t'(regWrData);
  end

  // External input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], extClkIn};
  end

  assign extLevel = ctrlReg.bypassSync ? extClkIn : syncChain[SYNC_STAGES-1];
  assign riseDet  = extLevel & ~prevLevel;
  assign fallDet  = ~extLevel & prevLevel;

  assign countWrite     = regWrEn && (regAddr == ADDR_CNT_LO || regAddr == ADDR_CNT_HI);
  assign reEnableDisarm = ctrlReg.run && !runD && lvlAtStop && !extLevel;

  // Edge history, stop-level capture and arming flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= 1'b0;
      runD      <= 1'b0;
      lvlAtStop <= 1'b0;
      armed     <= 1'b0;
    end else begin
      prevLevel <= extLevel;
      runD      <= ctrlReg.run;
      if (runD && !ctrlReg.run) lvlAtStop <= extLevel;
      if (countWrite || reEnableDisarm) armed <= 1'b0;
      else if (fallDet)                 armed <= 1'b1;
    end
  end

  // Source select and gate qualification
  assign srcTick    = ctrlReg.srcExt ? (riseDet & armed) : instrTick;
  assign gateLevel  = (ctrlReg.gateSel ? cmpOut : gatePin) ^ ctrlReg.gateInv;
  assign allowCount = ctrlReg.run & (~ctrlReg.gateEn | gateLevel);
  assign gatedTick  = srcTick & allowCount;

  // Prescaler
  assign divLimit = PS_CNT_W'((1 << ctrlReg.prescale) - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              psCnt <= '0;
    else if (countWrite)    psCnt <= '0;
    else if (gatedTick)     psCnt <= (psCnt == divLimit) ? '0 : psCnt + 1'b1;
  end

  always_comb begin
    strobe          = '0;
    strobe.incr     = gatedTick && (psCnt == divLimit);
    strobe.loadLo   = regWrEn && regAddr == ADDR_CNT_LO;
    strobe.loadHi   = regWrEn && regAddr == ADDR_CNT_HI;
    strobe.loadFlag = regWrEn && regAddr == ADDR_STAT;
  end
endmodule

// File: rtl/gtt_datapath.sv
module gtt_datapath
  import gtt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strobe,
  input  logic [BYTE_W-1:0]  regWrData,
  input  logic [ADDR_W-1:0]  regAddr,
  input  tmrCtrl_t           ctrlReg,
  output logic [COUNT_W-1:0] countVal,
  output logic               ovfFlag,
  output logic [BYTE_W-1:0]  regRdData
);
  logic anyLoad, wrapNow;

  assign anyLoad = strobe.loadLo | strobe.loadHi;
  assign wrapNow = strobe.incr && !anyLoad && (countVal == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (anyLoad) begin
      if (strobe.loadLo) countVal[BYTE_W-1:0]       <= regWrData;
      if (strobe.loadHi) countVal[COUNT_W-1:BYTE_W] <= regWrData;
    end else if (strobe.incr) begin
      countVal <= countVal + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ovfFlag <= 1'b0;
    else if (wrapNow)         ovfFlag <= 1'b1;
    else if (strobe.loadFlag) ovfFlag <= regWrData[0];
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CNT_LO: regRdData = countVal[BYTE_W-1:0];
      ADDR_CNT_HI: regRdData = countVal[COUNT_W-1:BYTE_W];
      ADDR_CTRL:   regRdData = ctrlReg;
      default:     regRdData = {{(BYTE_W-1){1'b0}}, ovfFlag};
    endcase
  end
endmodule

// File: rtl/gated_tick_timer.sv
module gated_tick_timer
  import gtt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrTick,
  input  logic              extClkIn,
  input  logic              gatePin,
  input  logic              cmpOut,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              ovfFlag
);
  tmrCtrl_t           ctrlReg;
  tmrStrobe_t         strobe;
  logic [COUNT_W-1:0] countVal;

  gtt_control #(.SYNC_STAGES(2), .PS_FIELD_W(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .instrTick(instrTick), .extClkIn(extClkIn),
    .gatePin(gatePin), .cmpOut(cmpOut), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .ctrlReg(ctrlReg), .strobe(strobe)
  );

  gtt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .regAddr(regAddr), .ctrlReg(ctrlReg), .countVal(countVal),
    .ovfFlag(ovfFlag), .regRdData(regRdData)
  );
endmodule

// File: rtl/gtt_checker.sv
module gtt_checker
  import gtt_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [BYTE_W-1:0]  regWrData,
  input logic [COUNT_W-1:0] countVal,
  input logic               ovfFlag,
  input logic               ctrlRun,
  input logic               ctrlSrcExt,
  input logic               incr
);
  logic cntWr;
  assign cntWr = regWrEn && (regAddr == ADDR_CNT_LO || regAddr == ADDR_CNT_HI);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(regWrEn && regAddr == ADDR_STAT)) |=> ovfFlag);

  // R9
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incr && !cntWr && countVal == '1) |=> (countVal == '0 && ovfFlag));

  // R4
  write_lo_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CNT_LO) |=> (countVal[BYTE_W-1:0] == $past(regWrData)));

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRun && !cntWr) |=> $stable(countVal));

  // R6
  write_disarms_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntWr && ctrlSrcExt) |=> (!incr || !ctrlSrcExt));
endmodule

bind gated_tick_timer gtt_checker u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .countVal(countVal), .ovfFlag(ovfFlag),
  .ctrlRun(ctrlReg.run), .ctrlSrcExt(ctrlReg.srcExt), .incr(strobe.incr)
);

// File: tb/tb_gated_tick_timer.sv
`timescale 1ns/1ps
module tb_gated_tick_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instrTick = 1'b0, extClkIn = 1'b0, gatePin = 1'b0, cmpOut = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       ovfFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gated_tick_timer dut (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic        pin;
    logic        cmp;
    logic [15:0] start;
    logic [7:0]  ticks;
    logic [15:0] expCount;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{8'h01, 1'b0, 1'b0, 16'h0000, 8'd10, 16'h000A}, // R2 div1
    '{8'h41, 1'b0, 1'b0, 16'h0100, 8'd10, 16'h0105}, // R3 div2
    '{8'h81, 1'b0, 1'b0, 16'h12FE, 8'd10, 16'h1300}, // R3 div4 byte carry
    '{8'hC1, 1'b0, 1'b0, 16'h0000, 8'd20, 16'h0002}, // R3 div8
    '{8'h09, 1'b0, 1'b0, 16'h0050, 8'd7,  16'h0050}, // R7 pin gate low
    '{8'h09, 1'b1, 1'b0, 16'h0050, 8'd7,  16'h0057}, // R7 pin gate high
    '{8'h19, 1'b0, 1'b0, 16'h0050, 8'd7,  16'h0057}, // R8 pin inverted
    '{8'h29, 1'b1, 1'b0, 16'h0200, 8'd5,  16'h0200}, // R7 cmp selected, low
    '{8'h39, 1'b0, 1'b0, 16'h0200, 8'd5,  16'h0205}, // R8 cmp inverted
    '{8'h00, 1'b0, 1'b0, 16'h0300, 8'd6,  16'h0300}, // R2 run off
    '{8'h29, 1'b0, 1'b1, 16'h0400, 8'd4,  16'h0404}  // R7 cmp high
  };

  function automatic string vecReq(int k);
    case (k)
      0, 9:       return "R2";
      1, 2, 3:    return "R3";
      4, 5, 7, 10: return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic readCount(output logic [15:0] c);
    logic [7:0] lo, hi;
    regRead(2'd0, lo);
    regRead(2'd1, hi);
    c = {hi, lo};
  endtask

  task automatic pulseTicks(input int n);
    @(negedge clk);
    instrTick = 1'b1;
    repeat (n) @(negedge clk);
    instrTick = 1'b0;
  endtask

  task automatic setExt(input logic v);
    @(negedge clk);
    extClkIn = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic loadCount(input logic [15:0] v);
    regWrite(2'd0, v[7:0]);
    regWrite(2'd1, v[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0]  rd;
    logic [15:0] cnt, base;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(a[1:0], rd);
      check(rd == 8'h00, "R1 reset read", rd, 0);
    end

    // R1 control read-back
    regWrite(2'd2, 8'hA4);
    regRead(2'd2, rd);
    check(rd == 8'hA4, "R1 ctrl readback", rd, 8'hA4);

    // Vector table
    for (int k = 0; k < NVEC; k++) begin
      regWrite(2'd2, VECS[k].ctrl & 8'hFE);
      gatePin = VECS[k].pin;
      cmpOut  = VECS[k].cmp;
      loadCount(VECS[k].start);
      regWrite(2'd2, VECS[k].ctrl);
      pulseTicks(VECS[k].ticks);
      readCount(cnt);
      check(cnt == VECS[k].expCount, vecReq(k), cnt, VECS[k].expCount);
    end
    gatePin = 1'b0; cmpOut = 1'b0;

    // R4 prescaler cleared by count write: div4, 2 ticks, write, 3 ticks -> no increment
    regWrite(2'd2, 8'h80);
    loadCount(16'h0000);
    regWrite(2'd2, 8'h81);
    pulseTicks(2);
    regWrite(2'd0, 8'h20);
    pulseTicks(3);
    readCount(cnt);
    check(cnt == 16'h0020, "R4 prescaler clear", cnt, 16'h0020);

    // R4 write beats increment in the same cycle
    regWrite(2'd2, 8'h01);
    loadCount(16'h0540);
    @(negedge clk);
    instrTick = 1'b1; regAddr = 2'd0; regWrData = 8'h33; regWrEn = 1'b1;
    @(negedge clk);
    instrTick = 1'b0; regWrEn = 1'b0;
    readCount(cnt);
    check(cnt == 16'h0533, "R4 write priority", cnt, 16'h0533);

    // R9 wrap and sticky flag
    regWrite(2'd2, 8'h00);
    loadCount(16'hFFFF);
    regWrite(2'd2, 8'h01);
    pulseTicks(1);
    readCount(cnt);
    check(cnt == 16'h0000, "R9 wrap count", cnt, 0);
    check(ovfFlag == 1'b1, "R9 flag set", ovfFlag, 1);
    pulseTicks(3);
    regRead(2'd3, rd);
    check(rd == 8'h01, "R9 flag sticky", rd, 1);
    regWrite(2'd3, 8'h00);
    regRead(2'd3, rd);
    check(rd == 8'h00, "R9 flag cleared", rd, 0);

    // R6 arming after enable: ext low, first rise not counted
    regWrite(2'd2, 8'h02);
    loadCount(16'h0000);
    regWrite(2'd2, 8'h03);
    setExt(1'b1);
    readCount(cnt);
    check(cnt == 16'h0000, "R6 unarmed rise ignored", cnt, 0);
    setExt(1'b0);
    setExt(1'b1);
    readCount(cnt);
    check(cnt == 16'h0001, "R5 synced rise counted", cnt, 1);

    // R6 re-enable with high-at-stop, low-at-restart disarms
    regWrite(2'd2, 8'h02);
    repeat (3) @(negedge clk);
    setExt(1'b0);
    regWrite(2'd2, 8'h03);
    setExt(1'b1);
    readCount(cnt);
    check(cnt == 16'h0001, "R6 re-enable disarm", cnt, 1);
    setExt(1'b0);
    setExt(1'b1);
    readCount(cnt);
    check(cnt == 16'h0002, "R6 rearmed count", cnt, 2);

    // R6 count write disarms
    setExt(1'b0);
    regWrite(2'd0, 8'h10);
    setExt(1'b1);
    readCount(cnt);
    check(cnt == 16'h0010, "R6 write disarm", cnt, 16'h0010);

    // R5 bypass latency: one clock edge
    regWrite(2'd2, 8'h07);
    setExt(1'b0);
    readCount(base);
    @(negedge clk);
    extClkIn = 1'b1;
    @(negedge clk);
    regAddr = 2'd0;
    #1 check(regRdData == base[7:0] + 8'd1, "R5 bypass latency", regRdData, base[7:0] + 8'd1);

    // R5 synchronized latency: third clock edge
    regWrite(2'd2, 8'h03);
    setExt(1'b0);
    readCount(base);
    @(negedge clk);
    extClkIn = 1'b1;
    regAddr = 2'd0;
    @(negedge clk);
    @(negedge clk);
    #1 check(regRdData == base[7:0], "R5 sync not yet", regRdData, base[7:0]);
    @(negedge clk);
    #1 check(regRdData == base[7:0] + 8'd1, "R5 sync third edge", regRdData, base[7:0] + 8'd1);

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule